// File: doc/BRIEF.md
# Serial Byte Receiver with Centre-of-Bit Sampling

This block takes an asynchronous serial line that rests high and turns each frame of one low start bit, eight data bits (least significant first) and one high stop bit into a parallel byte. The line is first brought into the local clock domain through a two-flop synchroniser. A baud counter, sized from a divisor parameter, times every bit, and the divisor is the clock frequency divided by the bit rate.

A seven-state machine recognises the falling edge of a start bit and waits half a bit period. At that point it confirms that the line is still low. It then samples each data bit one full bit period after the previous sample, so every sample falls near the centre of its bit. One more full period later it reads the stop bit. A good stop bit produces a one-cycle valid strobe with the byte. A low stop bit produces a one-cycle framing-error strobe instead, and the byte is discarded.

Top module: `serial_byte_rx`

## Requirements
- R1: While reset is asserted and after its release, `rx_valid` and `rx_ferr` are 0 and `rx_data` is 8'h00 until the first frame completes.
- R2: The serial input is read only through a two-flop synchroniser that resets to 1. A low level seen by the idle machine starts a frame.
- R3: The eight data bits are taken least significant bit first. Bit 0 of `rx_data` holds the first bit after the start bit.
- R4: The start bit is re-checked `CLK_DIV/2` cycles after it is recognised. Each data bit and the stop bit are sampled exactly `CLK_DIV` cycles after the previous sample, and the baud counter restarts on every state change.
- R5: A high stop bit loads the byte into `rx_data` and raises `rx_valid`. Frames sent back to back, with no idle time between a stop bit and the next start bit, are each received.
- R6: If the line is high again at the half-bit check, the frame is abandoned and the machine returns to idle. No strobe is produced, and the next real frame is received normally.
- R7: A low stop bit raises `rx_ferr` and leaves `rx_valid` low for that frame. `rx_data` keeps the last good byte.
- R8: `rx_valid` and `rx_ferr` are each high for exactly one clock cycle per frame, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_line | input | 1 | Serial line; rests high |
| rx_data | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` has just been loaded |
| rx_ferr | output | 1 | One-cycle strobe: stop bit was low, byte discarded |

## Verification
The bench sends every one of the 256 byte values, mostly back to back. This exposes a bit-order swap, a counter that drifts by a cycle per bit and so slides samples into the neighbouring bit, and a machine that misses a start edge arriving straight after a stop bit. It also injects frames with a low stop bit. A design that ignores the stop bit would strobe a bad byte, and one that overwrites the output register would lose the last good value. Short low glitches are injected as well; a receiver without the half-bit re-check would report a spurious byte or framing error. Each strobe is watched so that one lasting more than a cycle, or both strobes appearing together, is reported.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HALF,
    ST_COUNT,
    ST_SHIFT,
    ST_DONE,
    ST_STOP
  } sbr_state_e;
endpackage

// File: rtl/sbr_rst_sync.sv
module sbr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage;

  // Assert at once, release two edges later.
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage <= 2'b00;
    else           stage <= {stage[0], 1'b1};
  end

  assign rst_n_out = stage[1];
endmodule

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/sbr_baud_cnt.sv
module sbr_baud_cnt #(
  parameter int CLK_DIV = 16,
  localparam int CNT_W = $clog2(CLK_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R4: the counter never runs past one bit period
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CLK_DIV - 1));
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int CLK_DIV   = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_ferr
);
  import sbr_pkg::*;

  localparam int CNT_W   = $clog2(CLK_DIV + 1);
  localparam int BIT_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF    = CLK_DIV / 2;
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] FULL_END = CNT_W'(CLK_DIV - 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  logic                 rst_n_s;
  logic                 rx_s;
  logic [CNT_W-1:0]     cnt;
  logic                 cnt_clr;
  sbr_state_e           state, state_d;
  logic [BIT_W-1:0]     bit_cnt, bit_cnt_d;
  logic [DATA_BITS-1:0] shreg, shreg_d;
  logic [DATA_BITS-1:0] data_d;
  logic                 valid_d, ferr_d;

  sbr_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  sbr_sync #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din(rx_line), .dout(rx_s));

  sbr_baud_cnt #(.CLK_DIV(CLK_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .clr(cnt_clr), .cnt(cnt));

  // Counter restarts on every state change and rests in idle.
  assign cnt_clr = (state_d != state) || (state == ST_IDLE);

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE:  if (!rx_s) state_d = ST_START;
      ST_START: state_d = ST_HALF;
      ST_HALF:  if (cnt == HALF_END) state_d = rx_s ? ST_IDLE : ST_COUNT;
      ST_COUNT: if (cnt == FULL_END) state_d = ST_SHIFT;
      ST_SHIFT: state_d = (bit_cnt == LAST_BIT) ? ST_DONE : ST_COUNT;
      ST_DONE:  if (cnt == FULL_END) state_d = ST_STOP;
      ST_STOP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    bit_cnt_d = bit_cnt;
    shreg_d   = shreg;
    data_d    = rx_data;
    valid_d   = 1'b0;
    ferr_d    = 1'b0;
    case (state)
      ST_START: bit_cnt_d = '0;
      ST_SHIFT: begin
        shreg_d   = {rx_s, shreg[DATA_BITS-1:1]};
        bit_cnt_d = bit_cnt + BIT_W'(1);
      end
      ST_STOP: begin
        if (rx_s) begin
          data_d  = shreg;
          valid_d = 1'b1;
        end else begin
          ferr_d  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      state    <= state_d;
      bit_cnt  <= bit_cnt_d;
      shreg    <= shreg_d;
      rx_data  <= data_d;
      rx_valid <= valid_d;
      rx_ferr  <= ferr_d;
    end
  end

  // R8: strobes last a single cycle and never coincide
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_valid |=> !rx_valid);
  p_ferr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_ferr |=> !rx_ferr);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_valid |-> !rx_ferr);
  // R5: a valid strobe only follows the stop-bit check
  p_valid_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_valid |-> $past(state) == ST_STOP);
  // R7: a framing error leaves the output byte untouched
  p_ferr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_ferr |-> rx_data == $past(rx_data));
  // R6: line high at the half-bit check abandons the frame
  p_glitch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_HALF && cnt == HALF_END && rx_s) |=> state == ST_IDLE);
  // R3: the last data bit leads to the stop-bit wait
  p_last_bit_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state == ST_SHIFT && bit_cnt == LAST_BIT) |=> state == ST_DONE);
endmodule

// File: tb/tb_serial_byte_rx.sv
module tb_serial_byte_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 16;

  logic       clk;
  logic       rst_n;
  logic       rx_line;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ferr;

  int checks = 0;
  int fails  = 0;
  int valid_seen = 0;
  int ferr_seen  = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_valid = 1'b0;
  logic prev_ferr  = 1'b0;
  logic monitor_on = 1'b0;
  bit   finished   = 1'b0;

  serial_byte_rx #(.CLK_DIV(DIV), .DATA_BITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (monitor_on) begin
      if (rx_valid) begin
        valid_seen++;
        last_byte = rx_data;
      end
      if (rx_ferr) ferr_seen++;
      // R8: one-cycle strobes, never both at once
      if (rx_valid && prev_valid) check(0, "R8 valid width", 2, 1);
      if (rx_ferr && prev_ferr)   check(0, "R8 ferr width", 2, 1);
      if (rx_valid && rx_ferr)    check(0, "R8 exclusive", 1, 0);
      prev_valid = rx_valid;
      prev_ferr  = rx_ferr;
    end
  end

  task automatic drive_bit(input logic v);
    rx_line = v;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop);
  endtask

  task automatic idle_bits(input int n);
    rx_line = 1'b1;
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic good_frame(input logic [7:0] b);
    int v0, f0;
    v0 = valid_seen;
    f0 = ferr_seen;
    send_frame(b, 1'b1);
    // R3 R4 R5: byte assembled LSB first from centre samples, one strobe
    check(valid_seen == v0 + 1, "R5 strobe count", valid_seen - v0, 1);
    check(last_byte == b, "R3 byte at strobe", last_byte, b);
    check(rx_data == b, "R4 rx_data held", rx_data, b);
    check(ferr_seen == f0, "R5 no ferr", ferr_seen - f0, 0);
  endtask

  task automatic bad_frame(input logic [7:0] b, input logic [7:0] keep);
    int v0, f0;
    v0 = valid_seen;
    f0 = ferr_seen;
    send_frame(b, 1'b0);
    idle_bits(2);
    // R7: low stop bit -> ferr strobe, no valid, data kept
    check(ferr_seen == f0 + 1, "R7 ferr strobe", ferr_seen - f0, 1);
    check(valid_seen == v0, "R7 no valid", valid_seen - v0, 0);
    check(rx_data == keep, "R7 data kept", rx_data, keep);
  endtask

  task automatic glitch(input int low_cycles, input logic [7:0] keep);
    int v0, f0;
    v0 = valid_seen;
    f0 = ferr_seen;
    rx_line = 1'b0;
    repeat (low_cycles) @(negedge clk);
    idle_bits(3);
    // R6: short low pulse produces nothing
    check(valid_seen == v0, "R6 no valid", valid_seen - v0, 0);
    check(ferr_seen == f0, "R6 no ferr", ferr_seen - f0, 0);
    check(rx_data == keep, "R6 data kept", rx_data, keep);
  endtask

  initial begin
    logic [7:0] last_good;
    rst_n   = 1'b0;
    rx_line = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rx_valid == 1'b0, "R1 valid in reset", rx_valid, 0);
    check(rx_ferr == 1'b0, "R1 ferr in reset", rx_ferr, 0);
    check(rx_data == 8'h00, "R1 data in reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    monitor_on = 1'b1;
    check(rx_valid == 1'b0 && rx_ferr == 1'b0, "R1 quiet after reset",
          {rx_valid, rx_ferr}, 0);
    check(rx_data == 8'h00, "R1 data after reset", rx_data, 0);
    // R2: line held high by the idle bench gives no activity
    idle_bits(4);
    check(valid_seen == 0 && ferr_seen == 0, "R2 idle line", valid_seen + ferr_seen, 0);

    last_good = 8'h00;
    for (int b = 0; b < 256; b++) begin
      if (b % 64 == 0) glitch(2 + (b / 64), last_good);
      good_frame(8'(b));       // back to back with the previous frame
      last_good = 8'(b);
      if (b % 37 == 5) begin
        bad_frame(~8'(b), last_good);
      end
    end

    // R5: burst of alternating patterns with no idle gap
    good_frame(8'h55);
    good_frame(8'hAA);
    good_frame(8'h01);
    good_frame(8'h80);
    last_good = 8'h80;
    // R6: glitch just shorter than half a bit
    glitch(DIV / 2 - 4, last_good);
    good_frame(8'hC3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule